// File: doc/BRIEF.md
# Memory protection region register file

This block holds the configuration of a memory protection unit that has a parameterised number of regions. It keeps two complete copies of that configuration, one per security state. Each copy has a control word, a current-region pointer, and for every region a base word and an attribute/size word. A simple write bus supplies a word offset, write data, a write strobe and a secure flag, and the secure flag picks the copy. A combinational read port returns the addressed word of the same copy. Every stored region field and both control words are brought out as flat vectors. A one-cycle invalidate pulse tells downstream lookup logic to discard cached results.

Two layouts are fixed at build time by the `EXT` parameter. In the classic layout a base write may name its own target region and move the pointer there, and the stored words are masked. In the extended layout the base and attribute windows at the three alias offsets replace the low two bits of the pointer, and the stored words are kept unmasked. Each write passes through a two-state sequencer. In `ST_IDLE` a strobed write is captured and the sequencer moves to `ST_APPLY`. In `ST_APPLY` the captured write is committed. The sequencer stays in `ST_APPLY` if a new write is strobed in that cycle, and otherwise returns to `ST_IDLE`. A write strobed in cycle n therefore changes the state at the edge that ends cycle n+1, and its invalidate pulse is high during cycle n+2.

Top module: `mpu_regfile`

## Requirements
- R1: The control word at offset 0xD94 keeps only write-data bits 2:0 (bit 0 enable, bit 1 keep active during hard-fault/NMI handling, bit 2 privileged default map). A read returns those bits with bits 31:3 as zero, and every control write is accepted.
- R2: A write to the region pointer at 0xD98 with a value at or above NREG leaves the pointer unchanged. A read of 0xD98 returns the pointer.
- R3: In the classic layout, a base write with bit 4 set targets the region in bits 3:0 and also loads that number into the pointer. If that number is at or above NREG, the whole write is dropped and the pointer is kept.
- R4: In the classic layout, the stored base word has bits 4:0 cleared. A base read returns stored bits 31:5, a zero in bit 4 and pointer bits 3:0.
- R5: In the classic layout, an attribute write stores write-data AND 0x173FFF3F: the upper half masked with 0x173F and the lower half with 0xFF3F.
- R6: The base windows sit at 0xD9C+8k and the attribute windows at 0xDA0+8k for k = 0..3. In the classic layout all four windows act on the pointed region. A write to any other offset changes nothing and gives no invalidate.
- R7: In the extended layout, window k with k not zero targets the pointer with bits 1:0 replaced by k, and window 0 targets the pointer itself. The word is stored unmasked, and a read through a window returns the word of its target region.
- R8: A base or attribute write whose target region is at or above NREG changes nothing and gives no invalidate. An extended-layout read of such a target returns zero.
- R9: An accepted control, base or attribute write raises inval_o for exactly the cycle that follows its commit edge, two edges after the strobe. Region outputs and control outputs change only at such commits.
- R10: bus_sec=1 selects copy 1 (secure) and bus_sec=0 selects copy 0 (non-secure), for both writes and reads. A write never changes the other copy.
- R11: After reset every stored word, both pointers and inval_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Word offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_sec | input | 1 | Security state of the access; selects the copy |
| rd_data | output | 32 | Read data for bus_addr in the selected copy |
| ctrl_o | output | 6 | Control bits, copy b at [3b+2:3b] |
| rgn_base_o | output | 2*NREG*32 | Base word of region r of copy b at [(b*NREG+r)*32 +: 32] |
| rgn_cfg_o | output | 2*NREG*32 | Attribute/size word, same layout as rgn_base_o |
| inval_o | output | 1 | One-cycle pulse after each accepted change |

## Verification
The checker checks several things on every cycle. Control reads have zero upper bits. Pointer reads stay below NREG. Classic base reads show a zero in bit 4, and classic attribute reads never carry a bit outside the mask. Every invalidate pulse traces back to a strobe two cycles earlier, and no output changes in a cycle without a pulse. The bench scenarios cover what needs a reference model. These are the exact stored values for each target region, VALID retargeting and its dropped out-of-range case, alias splicing onto the pointer, out-of-range pointer writes, isolation between the two copies, and the absence of a pulse for ignored writes.

// File: rtl/mpu_rf_pkg.sv
package mpu_rf_pkg;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_CTRL = 3'd1,
        K_RNR  = 3'd2,
        K_BASE = 3'd3,
        K_ATTR = 3'd4
    } kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_APPLY = 1'b1
    } fsm_e;

    typedef struct packed {
        kind_e      kind;
        logic [1:0] win;
    } dec_t;

    localparam logic [11:0] OFS_CTRL  = 12'hD94;
    localparam logic [11:0] OFS_RNR   = 12'hD98;
    localparam logic [11:0] OFS_WIN0  = 12'hD9C;
    localparam logic [11:0] OFS_WLAST = 12'hDB8;

endpackage

// File: rtl/mpu_rf_decode.sv
module mpu_rf_decode
    import mpu_rf_pkg::*;
(
    input  logic [11:0] ofs,
    output dec_t        dec
);

    logic [11:0] diff;

    assign diff = ofs - OFS_WIN0;

    always_comb begin
        dec.kind = K_NONE;
        dec.win  = 2'd0;
        if (ofs == OFS_CTRL) begin
            dec.kind = K_CTRL;
        end else if (ofs == OFS_RNR) begin
            dec.kind = K_RNR;
        end else if (ofs >= OFS_WIN0 && ofs <= OFS_WLAST && ofs[1:0] == 2'b00) begin
            dec.kind = diff[2] ? K_ATTR : K_BASE;
            dec.win  = diff[4:3];
        end
    end

endmodule

// File: rtl/mpu_rf_bank.sv
module mpu_rf_bank
    import mpu_rf_pkg::*;
#(
    parameter int NREG = 8,
    parameter bit EXT  = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  kind_e                wkind,
    input  logic [1:0]           wwin,
    input  logic [31:0]          wdata,
    input  kind_e                rkind,
    input  logic [1:0]           rwin,
    output logic [2:0]           ctrl_o,
    output logic [NREG*32-1:0]   base_o,
    output logic [NREG*32-1:0]   cfg_o,
    output logic [31:0]          rd_o,
    output logic                 acc_o
);

    localparam int          IW    = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [7:0]  NLIM  = 8'(NREG);
    localparam logic [31:0] BMASK = EXT ? 32'hFFFF_FFFF : 32'hFFFF_FFE0;
    localparam logic [31:0] CMASK = EXT ? 32'hFFFF_FFFF : 32'h173F_FF3F;

    logic [2:0]    ctrl_q;
    logic [IW-1:0] rnr_q;
    logic [31:0]   base_q [NREG];
    logic [31:0]   cfg_q  [NREG];

    logic [7:0]    rnr8;
    logic [7:0]    w_tgt, r_tgt;
    logic          w_ok, r_ok;
    logic [IW-1:0] w_idx, r_idx;

    function automatic logic [7:0] splice(input logic [7:0] cur, input logic [1:0] w);
        return (w == 2'd0) ? cur : {cur[7:2], w};
    endfunction

    assign rnr8 = 8'(rnr_q);

    // Target region of the committed write
    always_comb begin
        if (EXT)
            w_tgt = splice(rnr8, wwin);
        else if (wkind == K_BASE && wdata[4])
            w_tgt = {4'b0000, wdata[3:0]};
        else
            w_tgt = rnr8;
    end

    assign w_ok  = (w_tgt < NLIM);
    assign w_idx = w_tgt[IW-1:0];
    assign acc_o = we && ((wkind == K_CTRL) ||
                          (((wkind == K_BASE) || (wkind == K_ATTR)) && w_ok));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rnr_q  <= '0;
            for (int i = 0; i < NREG; i++) begin
                base_q[i] <= '0;
                cfg_q[i]  <= '0;
            end
        end else if (we) begin
            case (wkind)
                K_CTRL: ctrl_q <= wdata[2:0];
                K_RNR: begin
                    if (wdata < 32'(NREG))
                        rnr_q <= wdata[IW-1:0];
                end
                K_BASE: begin
                    if (w_ok) begin
                        base_q[w_idx] <= wdata & BMASK;
                        if (!EXT && wdata[4])
                            rnr_q <= w_idx;
                    end
                end
                K_ATTR: begin
                    if (w_ok)
                        cfg_q[w_idx] <= wdata & CMASK;
                end
                default: ;
            endcase
        end
    end

    // Read side
    assign r_tgt = EXT ? splice(rnr8, rwin) : rnr8;
    assign r_ok  = (r_tgt < NLIM);
    assign r_idx = r_tgt[IW-1:0];

    always_comb begin
        rd_o = '0;
        case (rkind)
            K_CTRL: rd_o = {29'b0, ctrl_q};
            K_RNR:  rd_o = 32'(rnr_q);
            K_BASE: begin
                if (!EXT)
                    rd_o = {base_q[r_idx][31:5], 1'b0, rnr8[3:0]};
                else if (r_ok)
                    rd_o = base_q[r_idx];
            end
            K_ATTR: begin
                if (r_ok)
                    rd_o = cfg_q[r_idx];
            end
            default: rd_o = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign base_o[g*32 +: 32] = base_q[g];
        assign cfg_o[g*32 +: 32]  = cfg_q[g];
    end

endmodule

// File: rtl/mpu_regfile.sv
module mpu_regfile
    import mpu_rf_pkg::*;
#(
    parameter int NREG = 8,
    parameter bit EXT  = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_we,
    input  logic                 bus_sec,
    output logic [31:0]          rd_data,
    output logic [5:0]           ctrl_o,
    output logic [2*NREG*32-1:0] rgn_base_o,
    output logic [2*NREG*32-1:0] rgn_cfg_o,
    output logic                 inval_o
);

    localparam int NB   = 2;
    localparam int BW   = NREG * 32;

    fsm_e        state_q, state_d;
    logic [11:0] cap_addr;
    logic [31:0] cap_data;
    logic        cap_sec;
    logic        inval_q;

    dec_t        wdec, rdec;
    logic [NB-1:0] bank_acc;
    logic [31:0]   bank_rd [NB];

    // State register and capture of the pending write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cap_addr <= '0;
            cap_data <= '0;
            cap_sec  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (bus_we) begin
                cap_addr <= bus_addr;
                cap_data <= bus_wdata;
                cap_sec  <= bus_sec;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (bus_we) state_d = ST_APPLY;
            ST_APPLY: state_d = bus_we ? ST_APPLY : ST_IDLE;
        endcase
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            inval_q <= 1'b0;
        else
            inval_q <= (state_q == ST_APPLY) && bank_acc[cap_sec];
    end

    assign inval_o = inval_q;

    mpu_rf_decode u_wdec (.ofs(cap_addr), .dec(wdec));
    mpu_rf_decode u_rdec (.ofs(bus_addr), .dec(rdec));

    for (genvar b = 0; b < NB; b++) begin : g_bank
        mpu_rf_bank #(.NREG(NREG), .EXT(EXT)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     ((state_q == ST_APPLY) && (cap_sec == 1'(b))),
            .wkind  (wdec.kind),
            .wwin   (wdec.win),
            .wdata  (cap_data),
            .rkind  (rdec.kind),
            .rwin   (rdec.win),
            .ctrl_o (ctrl_o[b*3 +: 3]),
            .base_o (rgn_base_o[b*BW +: BW]),
            .cfg_o  (rgn_cfg_o[b*BW +: BW]),
            .rd_o   (bank_rd[b]),
            .acc_o  (bank_acc[b])
        );
    end

    assign rd_data = bank_rd[bus_sec];

endmodule

// File: rtl/mpu_regfile_chk.sv
module mpu_regfile_chk
    import mpu_rf_pkg::*;
#(
    parameter int NREG = 8,
    parameter bit EXT  = 1'b0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [11:0]          bus_addr,
    input logic                 bus_we,
    input logic [31:0]          rd_data,
    input logic [5:0]           ctrl_o,
    input logic [2*NREG*32-1:0] rgn_base_o,
    input logic [2*NREG*32-1:0] rgn_cfg_o,
    input logic                 inval_o
);

    logic base_hit, attr_hit;

    assign base_hit = (bus_addr == 12'hD9C) || (bus_addr == 12'hDA4) ||
                      (bus_addr == 12'hDAC) || (bus_addr == 12'hDB4);
    assign attr_hit = (bus_addr == 12'hDA0) || (bus_addr == 12'hDA8) ||
                      (bus_addr == 12'hDB0) || (bus_addr == 12'hDB8);

    a_r1_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CTRL) |-> (rd_data[31:3] == 29'd0));

    a_r2_rnr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_RNR) |-> (rd_data < 32'(NREG)));

    a_r4_base_read_bit4: assert property (@(posedge clk) disable iff (!rst_n)
        (!EXT && base_hit) |-> (rd_data[4] == 1'b0));

    a_r5_attr_read_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (!EXT && attr_hit) |-> ((rd_data & ~32'h173F_FF3F) == 32'd0));

    a_r9_inval_origin: assert property (@(posedge clk) disable iff (!rst_n)
        inval_o |-> $past(bus_we, 2));

    a_r9_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !inval_o |-> ($stable(rgn_base_o) && $stable(rgn_cfg_o) && $stable(ctrl_o)));

endmodule

bind mpu_regfile mpu_regfile_chk #(.NREG(NREG), .EXT(EXT)) u_chk (.*);

// File: tb/sim_mpu_regfile.sv
module sim_mpu_regfile;

    localparam int NR = 6;
    localparam int BW = 2 * NR * 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_sec = 1'b0;

    logic [31:0]   rd0, rd1;
    logic [5:0]    c0, c1;
    logic [BW-1:0] b0, b1, a0, a1;
    logic          iv0, iv1;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    mpu_regfile #(.NREG(NR), .EXT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_sec(bus_sec), .rd_data(rd0), .ctrl_o(c0),
        .rgn_base_o(b0), .rgn_cfg_o(a0), .inval_o(iv0));

    mpu_regfile #(.NREG(NR), .EXT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_sec(bus_sec), .rd_data(rd1), .ctrl_o(c1),
        .rgn_base_o(b1), .rgn_cfg_o(a1), .inval_o(iv1));

    // Reference model: [layout][copy][region]; layout 0 classic, 1 extended
    logic [31:0] mb [2][2][NR];
    logic [31:0] ma [2][2][NR];
    logic [2:0]  mc [2][2];
    int          mr [2][2];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int tgt_of(input int m, input logic [11:0] a,
                                  input logic [31:0] d, input int s);
        int k;
        bit isattr;
        k      = int'((a - 12'hD9C) >> 3);
        isattr = ((a - 12'hD9C) & 12'h4) != 0;
        if (m == 0) begin
            if (!isattr && d[4]) return int'(d[3:0]);
            return mr[m][s];
        end
        return (k != 0) ? ((mr[m][s] & ~3) | k) : mr[m][s];
    endfunction

    function automatic bit is_win(input logic [11:0] a);
        return a >= 12'hD9C && a <= 12'hDB8 && a[1:0] == 2'b00;
    endfunction

    task automatic m_wr(input int m, input logic [11:0] a, input logic [31:0] d,
                        input int s, output bit acc);
        int t;
        bit isattr;
        acc = 1'b0;
        if (a == 12'hD94) begin
            mc[m][s] = d[2:0];
            acc = 1'b1;
        end else if (a == 12'hD98) begin
            if (d < NR) mr[m][s] = int'(d);
        end else if (is_win(a)) begin
            isattr = ((a - 12'hD9C) & 12'h4) != 0;
            t = tgt_of(m, a, d, s);
            if (t < NR) begin
                acc = 1'b1;
                if (!isattr) begin
                    mb[m][s][t] = (m == 1) ? d : (d & 32'hFFFF_FFE0);
                    if (m == 0 && d[4]) mr[m][s] = t;
                end else begin
                    ma[m][s][t] = (m == 1) ? d : (d & 32'h173F_FF3F);
                end
            end
        end
    endtask

    function automatic logic [31:0] exp_rd(input int m, input logic [11:0] a, input int s);
        int t;
        if (a == 12'hD94) return {29'b0, mc[m][s]};
        if (a == 12'hD98) return 32'(mr[m][s]);
        if (!is_win(a)) return 32'd0;
        t = tgt_of(m, a, 32'd0, s);
        if (((a - 12'hD9C) & 12'h4) == 0) begin
            if (m == 0) return {mb[m][s][t][31:5], 1'b0, 4'(mr[m][s])};
            return (t < NR) ? mb[m][s][t] : 32'd0;
        end
        return (t < NR) ? ma[m][s][t] : 32'd0;
    endfunction

    task automatic cmp_all(input string req);
        for (int m = 0; m < 2; m++) begin
            bit ok = 1'b1;
            logic [31:0] act = '0, exp = '0;
            for (int s = 0; s < 2; s++) begin
                logic [2:0] cact = (m == 0) ? c0[s*3 +: 3] : c1[s*3 +: 3];
                if (ok && cact != mc[m][s]) begin
                    ok = 1'b0; act = 32'(cact); exp = 32'(mc[m][s]);
                end
                for (int r = 0; r < NR; r++) begin
                    logic [31:0] bv = (m == 0) ? b0[(s*NR+r)*32 +: 32] : b1[(s*NR+r)*32 +: 32];
                    logic [31:0] av = (m == 0) ? a0[(s*NR+r)*32 +: 32] : a1[(s*NR+r)*32 +: 32];
                    if (ok && bv != mb[m][s][r]) begin
                        ok = 1'b0; act = bv; exp = mb[m][s][r];
                    end
                    if (ok && av != ma[m][s][r]) begin
                        ok = 1'b0; act = av; exp = ma[m][s][r];
                    end
                end
            end
            chk(ok, $sformatf("%s outputs layout%0d", req, m), act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input int s,
                      input string req);
        bit e0, e1;
        m_wr(0, a, d, s, e0);
        m_wr(1, a, d, s, e1);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_sec = 1'(s); bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
        chk(iv0 == e0, {req, " R9 inval layout0"}, 32'(iv0), 32'(e0));
        chk(iv1 == e1, {req, " R9 inval layout1"}, 32'(iv1), 32'(e1));
        @(negedge clk);
        chk(!iv0 && !iv1, "R9 pulse width", 32'({iv0, iv1}), 32'd0);
        cmp_all(req);
    endtask

    task automatic rdchk(input logic [11:0] a, input int s, input string req);
        logic [31:0] e0, e1;
        e0 = exp_rd(0, a, s);
        e1 = exp_rd(1, a, s);
        bus_addr = a; bus_sec = 1'(s);
        #1;
        chk(rd0 == e0, {req, " read layout0"}, rd0, e0);
        chk(rd1 == e1, {req, " read layout1"}, rd1, e1);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog R9 actual=%h expected=%h", 32'd1, 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 2; s++) begin
                mc[m][s] = '0;
                mr[m][s] = 0;
                for (int r = 0; r < NR; r++) begin
                    mb[m][s][r] = '0;
                    ma[m][s][r] = '0;
                end
            end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk(!iv0 && !iv1, "R11 inval after reset", 32'({iv0, iv1}), 32'd0);
        cmp_all("R11");
        for (int s = 0; s < 2; s++) begin
            rdchk(12'hD94, s, "R11 ctrl");
            rdchk(12'hD98, s, "R11 rnr");
        end

        // R1 and R10: control bits, copies kept apart
        wr(12'hD94, 32'hFFFF_FFFF, 1, "R1 ctrl all ones");
        rdchk(12'hD94, 1, "R1 ctrl");
        wr(12'hD94, 32'h0000_00F5, 0, "R10 ctrl nonsecure");
        rdchk(12'hD94, 1, "R10 secure copy kept");
        rdchk(12'hD94, 0, "R1 ctrl nonsecure");

        // R2: pointer range sweep
        for (int v = 0; v < 10; v++) begin
            wr(12'hD98, 32'(v), 1, "R2 rnr write");
            rdchk(12'hD98, 1, "R2 rnr");
        end
        wr(12'hD98, 32'hFFFF_FFFF, 1, "R2 rnr huge");
        rdchk(12'hD98, 1, "R2 rnr huge");

        // R4, R5, R10: fill every region of both copies via the pointer
        for (int s = 0; s < 2; s++)
            for (int r = 0; r < NR; r++) begin
                wr(12'hD98, 32'(r), s, "R10 point");
                wr(12'hD9C, 32'hA5A5_00EF ^ (32'(r) * 32'h0101_0100) ^ (32'(s) << 31),
                   s, "R4 base fill");
                wr(12'hDA0, 32'hFFFF_FFFF ^ (32'(r) << 8) ^ (32'(s) << 20), s, "R5 attr fill");
                rdchk(12'hD9C, s, "R4 base");
                rdchk(12'hDA0, s, "R5 attr");
            end

        // R3: classic retarget through bit 4
        for (int t = 0; t < 16; t++) begin
            wr(12'hD9C, 32'h1234_5600 | 32'h10 | 32'(t), 0, "R3 valid retarget");
            rdchk(12'hD98, 0, "R3 rnr");
        end

        // R6 classic windows; R7 and R8 extended splicing
        for (int i = 0; i < 3; i++) begin
            int rn = (i == 0) ? 1 : ((i == 1) ? 4 : 5);
            wr(12'hD98, 32'(rn), 1, "R7 point");
            for (int k = 0; k < 4; k++) begin
                wr(12'(12'hD9C + 8 * k), 32'hC0DE_0000 | 32'(rn * 16 + k) | 32'h1F0,
                   1, "R7 base window");
                wr(12'(12'hDA0 + 8 * k), 32'h8000_0001 ^ 32'(rn << 12) ^ 32'(k << 24),
                   1, "R8 attr window");
                rdchk(12'(12'hD9C + 8 * k), 1, "R6 base window");
                rdchk(12'(12'hDA0 + 8 * k), 1, "R8 attr window");
            end
        end

        // R6: unmapped offsets are ignored
        wr(12'hD90, 32'hFFFF_FFFF, 0, "R6 unmapped");
        wr(12'hDBC, 32'hFFFF_FFFF, 1, "R6 unmapped");
        wr(12'hD9E, 32'hFFFF_FFFF, 1, "R6 misaligned");
        rdchk(12'hD90, 0, "R6 unmapped");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule